// File: doc/BRIEF.md
# Power Controller Request Mailbox

This block is a small register file on a host bus that forwards requests to a slow power-management agent serving two processor clusters, a big one and a little one. Software asks for a performance level on either cluster, or issues a configuration-read command through a command word with a start bit. The agent's delay is modelled by a busy period of a set number of cycles. When the busy period ends, the block posts a completion bit or an error bit for that request type into one shared status word and raises a level interrupt.

Configuration reads in the operating-point space return 32-bit words from an internal table. Each word carries a voltage in its upper twelve bits and a frequency field in its lower twenty bits, and the frequency in kHz is twenty times that field. Configuration reads in the status space return the two clusters' current level indices. Only one request is in flight at a time. A request that arrives during the busy period is dropped.

Top module: `pwr_req_mailbox`

## Requirements
- R1: After reset, both level registers, the status word (offset 0x18) and the read-data register (0x74) read 0, and irq is low.
- R2: A write of index L to 0x00 (big cluster, type 0) or 0x08 (little cluster, type 1) starts a request. Exactly BUSY_CYCLES clock edges after the write edge, the completion bit at status bit 4*type is set and irq rises. On success the level register then reads back L.
- R3: If L is at or above the cluster's populated point count (N_OPP_BIG or N_OPP_LIT), the error bit at status bit 4*type+1 is set instead, and the level register keeps its old value.
- R4: A write to 0x10 with bit 31 set starts a config read (type 2). Bits [27:20] hold the function and bits [19:0] hold the byte offset divided by 4. With function 6 and an offset inside a populated table entry, status bit 8 is set and 0x74 then holds that entry's word.
- R5: Table entry i sits at byte offset 0xC10+4*i for the big cluster and 0xC30+4*i for the little cluster. For the big cluster the word is {12'(900+25*i), 20'(25000+5000*i)}. For the little cluster it is {12'(800+25*i), 20'(15000+2500*i)}.
- R6: A config read with an offset that is not populated, or with a function other than 6 or 14, sets status bit 9 and leaves 0x74 unchanged.
- R7: A write to 0x10 with bit 31 clear starts nothing: no status bit is set and irq stays low.
- R8: A request written while another is busy is ignored. It sets no status bit and changes no level register.
- R9: Reading 0x18 returns the status bits and clears them all. irq drops unless a new result is posted in the same cycle.
- R10: irq stays high while any status bit is set, so results accumulate until the status word is read.
- R11: During a request, 0x04, 0x0C or 0x14 reads 1 for a big-cluster, little-cluster or config request respectively. 0x1C reads 1 for any pending request.
- R12: A config read with function 14 and offset 0 completes with status bit 8. The word it returns has the big level in bits [2:0] and the little level in bits [6:4]; every other bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The bench builds the block with BUSY_CYCLES=6, N_OPP_BIG=5 and N_OPP_LIT=3. The short busy period lets the bench check the exact cycle in which irq rises, and lets it land a second request inside a busy window. The partly populated tables put the first unpopulated level index and the first empty table offset within reach for both clusters. They also let a last populated entry be read back and compared against the formula.

// File: rtl/pwrmb_pkg.sv
package pwrmb_pkg;

    localparam int MAX_OPP   = 8;
    localparam int LVL_W     = 3;
    localparam int STAT_W    = 12;

    localparam logic [7:0] A_BIG_LVL  = 8'h00;
    localparam logic [7:0] A_BIG_PEND = 8'h04;
    localparam logic [7:0] A_LIT_LVL  = 8'h08;
    localparam logic [7:0] A_LIT_PEND = 8'h0C;
    localparam logic [7:0] A_CMD      = 8'h10;
    localparam logic [7:0] A_CMD_PEND = 8'h14;
    localparam logic [7:0] A_STATUS   = 8'h18;
    localparam logic [7:0] A_FLAG     = 8'h1C;
    localparam logic [7:0] A_WDATA    = 8'h70;
    localparam logic [7:0] A_RDATA    = 8'h74;

    localparam logic [7:0]  FN_OPP  = 8'd6;
    localparam logic [7:0]  FN_STAT = 8'd14;
    localparam int          BIG_TBL_W = 'hC10 >> 2;
    localparam int          LIT_TBL_W = 'hC30 >> 2;

    typedef enum logic [1:0] {
        REQ_BIG = 2'd0,
        REQ_LIT = 2'd1,
        REQ_CFG = 2'd2
    } req_kind_e;

    typedef struct packed {
        req_kind_e   kind;
        logic [7:0]  func;
        logic [19:0] arg;
    } req_t;

    function automatic logic [31:0] opp_word(input logic lit, input int idx);
        int volt;
        int fld;
        if (lit) begin
            volt = 800 + 25 * idx;
            fld  = 15000 + 2500 * idx;
        end else begin
            volt = 900 + 25 * idx;
            fld  = 25000 + 5000 * idx;
        end
        return {volt[11:0], fld[19:0]};
    endfunction

    function automatic logic [3:0] stat_bit(input req_kind_e k, input logic err);
        return {k, 2'b00} + {3'b000, err};
    endfunction

endpackage

// File: rtl/pwrmb_opp_rom.sv
module pwrmb_opp_rom
    import pwrmb_pkg::*;
#(
    parameter int N_OPP_BIG = 8,
    parameter int N_OPP_LIT = 8
) (
    input  logic [19:0] word_off,
    output logic        hit,
    output logic [31:0] word
);

    always_comb begin
        hit  = 1'b0;
        word = '0;
        for (int i = 0; i < MAX_OPP; i++) begin
            if (i < N_OPP_BIG && word_off == 20'(BIG_TBL_W + i)) begin
                hit  = 1'b1;
                word = opp_word(1'b0, i);
            end
            if (i < N_OPP_LIT && word_off == 20'(LIT_TBL_W + i)) begin
                hit  = 1'b1;
                word = opp_word(1'b1, i);
            end
        end
    end

endmodule

// File: rtl/pwrmb_sequencer.sv
module pwrmb_sequencer
    import pwrmb_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  req_t req_i,
    output logic busy_o,
    output logic done_o,
    output req_t cur_o
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            cnt    <= '0;
            cur_o  <= '0;
        end else if (!busy_o && start_i) begin
            busy_o <= 1'b1;
            cnt    <= CNT_W'(BUSY_CYCLES);
            cur_o  <= req_i;
        end else if (busy_o) begin
            if (cnt == CNT_W'(1))
                busy_o <= 1'b0;
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done_o = busy_o && (cnt == CNT_W'(1));

    // a request landing in the busy window must not replace the one in flight
    assert_drop_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(cur_o));

    // the busy period ends at the completion edge
    assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

endmodule

// File: rtl/pwrmb_status.sv
module pwrmb_status
    import pwrmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              post_i,
    input  req_kind_e         post_kind_i,
    input  logic              post_err_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);

    logic [STAT_W-1:0] nxt;

    always_comb begin
        nxt = clr_i ? '0 : status_o;
        if (post_i)
            nxt[stat_bit(post_kind_i, post_err_i)] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) status_o <= '0;
        else     status_o <= nxt;
    end

    assign irq_o = |status_o;

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !post_i) |=> (!irq_o && status_o == '0));

    assert_post_raises_R10: assert property (@(posedge clk) disable iff (rst)
        post_i |=> irq_o);

    assert_held_until_read_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !clr_i) |=> irq_o);

endmodule

// File: rtl/pwr_req_mailbox.sv
module pwr_req_mailbox
    import pwrmb_pkg::*;
#(
    parameter int BUSY_CYCLES = 16,
    parameter int N_OPP_BIG   = 8,
    parameter int N_OPP_LIT   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);

    logic [LVL_W-1:0]  big_lvl, lit_lvl;
    logic [31:0]       cmd_q, wdata_q, rdata_q;
    logic              start;
    req_t              new_req, cur;
    logic              busy, done;
    logic              rom_hit;
    logic [31:0]       rom_word;
    logic              res_err;
    logic [31:0]       cfg_word;
    logic [STAT_W-1:0] status;
    logic              stat_clr;

    // request decode from the bus
    always_comb begin
        start   = 1'b0;
        new_req = '0;
        if (bus_wr) begin
            unique case (bus_addr)
                A_BIG_LVL: begin
                    start        = 1'b1;
                    new_req.kind = REQ_BIG;
                    new_req.arg  = {12'b0, bus_wdata[7:0]};
                end
                A_LIT_LVL: begin
                    start        = 1'b1;
                    new_req.kind = REQ_LIT;
                    new_req.arg  = {12'b0, bus_wdata[7:0]};
                end
                A_CMD: begin
                    start        = bus_wdata[31];
                    new_req.kind = REQ_CFG;
                    new_req.func = bus_wdata[27:20];
                    new_req.arg  = bus_wdata[19:0];
                end
                default: ;
            endcase
        end
    end

    pwrmb_sequencer #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .start_i(start), .req_i(new_req),
        .busy_o(busy), .done_o(done), .cur_o(cur)
    );

    pwrmb_opp_rom #(.N_OPP_BIG(N_OPP_BIG), .N_OPP_LIT(N_OPP_LIT)) u_rom (
        .word_off(cur.arg), .hit(rom_hit), .word(rom_word)
    );

    // outcome of the request in flight, judged at completion
    always_comb begin
        cfg_word = '0;
        res_err  = 1'b1;
        unique case (cur.kind)
            REQ_BIG: res_err = cur.arg >= 20'(N_OPP_BIG);
            REQ_LIT: res_err = cur.arg >= 20'(N_OPP_LIT);
            REQ_CFG: begin
                if (cur.func == FN_OPP) begin
                    res_err  = !rom_hit;
                    cfg_word = rom_word;
                end else if (cur.func == FN_STAT && cur.arg == '0) begin
                    res_err  = 1'b0;
                    cfg_word = {25'b0, lit_lvl, 1'b0, big_lvl};
                end
            end
            default: res_err = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            big_lvl <= '0;
            lit_lvl <= '0;
            rdata_q <= '0;
            cmd_q   <= '0;
            wdata_q <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CMD)   cmd_q   <= bus_wdata;
            if (bus_wr && bus_addr == A_WDATA) wdata_q <= bus_wdata;
            if (done && !res_err) begin
                unique case (cur.kind)
                    REQ_BIG: big_lvl <= cur.arg[LVL_W-1:0];
                    REQ_LIT: lit_lvl <= cur.arg[LVL_W-1:0];
                    default: rdata_q <= cfg_word;
                endcase
            end
        end
    end

    assign stat_clr = bus_rd && bus_addr == A_STATUS;

    pwrmb_status u_stat (
        .clk(clk), .rst(rst), .clr_i(stat_clr), .post_i(done),
        .post_kind_i(cur.kind), .post_err_i(res_err),
        .status_o(status), .irq_o(irq)
    );

    // registered read port
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                A_BIG_LVL:  bus_rdata <= {29'b0, big_lvl};
                A_BIG_PEND: bus_rdata <= {31'b0, busy && cur.kind == REQ_BIG};
                A_LIT_LVL:  bus_rdata <= {29'b0, lit_lvl};
                A_LIT_PEND: bus_rdata <= {31'b0, busy && cur.kind == REQ_LIT};
                A_CMD:      bus_rdata <= cmd_q;
                A_CMD_PEND: bus_rdata <= {31'b0, busy && cur.kind == REQ_CFG};
                A_STATUS:   bus_rdata <= {20'b0, status};
                A_FLAG:     bus_rdata <= {31'b0, busy};
                A_WDATA:    bus_rdata <= wdata_q;
                A_RDATA:    bus_rdata <= rdata_q;
                default:    bus_rdata <= '0;
            endcase
        end
    end

    assert_level_kept_on_error_R3: assert property (@(posedge clk) disable iff (rst)
        (done && res_err && cur.kind != REQ_CFG) |=> ($stable(big_lvl) && $stable(lit_lvl)));

    assert_rdata_kept_on_error_R6: assert property (@(posedge clk) disable iff (rst)
        (done && res_err) |=> $stable(rdata_q));

    assert_nostart_no_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && bus_wr && bus_addr == A_CMD && !bus_wdata[31]) |=> !busy);

endmodule

// File: tb/sim_pwr_req_mailbox.sv
module sim_pwr_req_mailbox;

    localparam int B    = 6;
    localparam int NBIG = 5;
    localparam int NLIT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    pwr_req_mailbox #(.BUSY_CYCLES(B), .N_OPP_BIG(NBIG), .N_OPP_LIT(NLIT)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] exp_opp(input bit lit, input int i);
        int v;
        int f;
        v = lit ? 800 + 25 * i : 900 + 25 * i;
        f = lit ? 15000 + 2500 * i : 25000 + 5000 * i;
        return {v[11:0], f[19:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cmd(input logic [7:0] fn, input int byte_off);
        int w;
        w = byte_off >> 2;
        return {1'b1, 3'b0, fn, w[19:0]};
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 0);
        rd(8'h00, d); check("R1 big level", d, 0);
        rd(8'h08, d); check("R1 little level", d, 0);
        rd(8'h74, d); check("R1 read data", d, 0);
        rd(8'h18, d); check("R1 status", d, 0);
    endtask

    task automatic t_big_ok;
        logic [31:0] d;
        wr(8'h00, 32'd3);
        idle(B - 1);
        check("R2 irq before busy end", {31'b0, irq}, 0);
        idle(1);
        check("R2 irq at busy end", {31'b0, irq}, 1);
        rd(8'h00, d); check("R2 big level", d, 3);
        rd(8'h18, d); check("R9 status value", d, 32'h1);
        check("R9 irq after read", {31'b0, irq}, 0);
        rd(8'h18, d); check("R9 status cleared", d, 0);
    endtask

    task automatic t_pending_flags;
        logic [31:0] d;
        wr(8'h08, 32'd2);
        rd(8'h0C, d); check("R11 little pending", d, 1);
        rd(8'h04, d); check("R11 big not pending", d, 0);
        rd(8'h1C, d); check("R11 any pending", d, 1);
        idle(B);
        rd(8'h0C, d); check("R11 little done", d, 0);
        rd(8'h08, d); check("R2 little level", d, 2);
        rd(8'h18, d); check("R2 little completion bit", d, 32'h10);
    endtask

    task automatic t_bad_level;
        logic [31:0] d;
        wr(8'h00, NBIG);
        idle(B + 1);
        rd(8'h18, d); check("R3 big error bit", d, 32'h2);
        rd(8'h00, d); check("R3 big level kept", d, 3);
        wr(8'h08, NLIT);
        idle(B + 1);
        rd(8'h18, d); check("R3 little error bit", d, 32'h20);
        rd(8'h08, d); check("R3 little level kept", d, 2);
    endtask

    task automatic t_cfg_reads;
        logic [31:0] d;
        wr(8'h10, cmd(8'd6, 'hC10 + 4 * (NBIG - 1)));
        rd(8'h14, d); check("R11 config pending", d, 1);
        idle(B);
        rd(8'h18, d); check("R4 config completion", d, 32'h100);
        rd(8'h74, d); check("R5 big last entry", d, exp_opp(0, NBIG - 1));
        wr(8'h10, cmd(8'd6, 'hC10));
        idle(B + 1);
        rd(8'h74, d); check("R5 big entry 0", d, exp_opp(0, 0));
        rd(8'h18, d); check("R4 status", d, 32'h100);
        wr(8'h10, cmd(8'd6, 'hC30 + 4 * (NLIT - 1)));
        idle(B + 1);
        rd(8'h74, d); check("R5 little last entry", d, exp_opp(1, NLIT - 1));
        rd(8'h18, d); check("R4 little status", d, 32'h100);
    endtask

    task automatic t_cfg_errors;
        logic [31:0] d;
        wr(8'h10, cmd(8'd6, 'hC10 + 4 * NBIG));
        idle(B + 1);
        rd(8'h18, d); check("R6 big offset error", d, 32'h200);
        rd(8'h74, d); check("R6 read data kept", d, exp_opp(1, NLIT - 1));
        wr(8'h10, cmd(8'd6, 'hC30 + 4 * NLIT));
        idle(B + 1);
        rd(8'h18, d); check("R6 little offset error", d, 32'h200);
        wr(8'h10, cmd(8'd3, 'hC10));
        idle(B + 1);
        rd(8'h18, d); check("R6 bad function", d, 32'h200);
        rd(8'h74, d); check("R6 read data still kept", d, exp_opp(1, NLIT - 1));
    endtask

    task automatic t_no_start;
        logic [31:0] d;
        wr(8'h10, cmd(8'd6, 'hC10) & 32'h7FFF_FFFF);
        rd(8'h1C, d); check("R7 nothing pending", d, 0);
        idle(B + 1);
        check("R7 irq low", {31'b0, irq}, 0);
        rd(8'h18, d); check("R7 no status", d, 0);
    endtask

    task automatic t_busy_drop;
        logic [31:0] d;
        wr(8'h00, 32'd1);
        wr(8'h08, 32'd0);
        wr(8'h10, cmd(8'd6, 'hC10));
        idle(B + 1);
        rd(8'h18, d); check("R8 only first posted", d, 32'h1);
        rd(8'h08, d); check("R8 little level untouched", d, 2);
        rd(8'h00, d); check("R8 big level from first", d, 1);
    endtask

    task automatic t_status_space;
        logic [31:0] d;
        wr(8'h10, cmd(8'd14, 0));
        idle(B + 1);
        rd(8'h18, d); check("R12 completion", d, 32'h100);
        rd(8'h74, d); check("R12 level word", d, 32'h21);
    endtask

    task automatic t_accumulate;
        logic [31:0] d;
        wr(8'h00, 32'd4);
        idle(B + 1);
        check("R10 irq after first", {31'b0, irq}, 1);
        wr(8'h08, 32'd7);
        idle(B + 1);
        check("R10 irq held", {31'b0, irq}, 1);
        rd(8'h18, d); check("R10 both bits kept", d, 32'h21);
        check("R9 irq dropped", {31'b0, irq}, 0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_big_ok();
        t_pending_flags();
        t_bad_level();
        t_cfg_reads();
        t_cfg_errors();
        t_no_start();
        t_busy_drop();
        t_status_space();
        t_accumulate();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule